// File: doc/BRIEF.md
# Fast-Page DRAM Access Controller

This block sits between a simple host request port and a 36-bit dynamic memory array that is 4M words deep and shares an 11-bit address bus between row and column. It turns each host read or write into a sequence of row strobes, column strobes, write enable and multiplexed address values. The word is split into four byte lanes of nine bits each (eight data bits plus one parity bit). Each lane has its own column strobe. Two row strobes each cover half of the word.

The controller keeps the last row open. A request that lands in the open row is served as a fast-page cycle with column activity only. A request to any other row first closes the row and waits out the full precharge. All writes are early writes, because the memory's data pins are shared between input and output. Every timing limit is a nanosecond parameter that is rounded up to whole clock cycles. A row is closed on its own before the maximum row-active time runs out.

While the controller is idle, a refresh sequencer can ask for the memory bus through a request/grant pair. The controller closes and precharges any open row before it grants, and it keeps its own strobes inactive for as long as the grant lasts.

Top module: `dram_page_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, both row strobes, all column strobes and write enable are high, the data drive enable is low, `ready_o` is high and `ref_gnt_o` and `rvalid_o` are low.
- R2: The row is `addr_i[21:11]` and the column is `addr_i[10:0]`. The row is on `dram_a_o` when the row strobes fall and the column is on `dram_a_o` when the column strobes fall. Both row strobes always move together.
- R3: The row strobes stay low for at least ceil(T_RAS/Tclk) cycles and high for at least ceil(T_RP/Tclk) cycles between openings. The first column strobe after a row opens falls at least ceil(T_RCD/Tclk) cycles after the row strobes fall.
- R4: Writes are early writes. Write enable is low and the data drive enable is high in the cycle before the column strobe falls, and both stay that way until it rises. On a write, lane k (`dram_dq_o[9k+8:9k]`, strobe `dram_cas_no[k]`) is strobed only when `be_i[k]` is 1. Unstrobed lanes keep their contents.
- R5: A read strobes all four lanes with write enable high and the drive enable low. The data is captured only once the column access time and the row access time have both elapsed. `rvalid_o` pulses for one cycle, in the first cycle after the column strobes rise, and `rdata_o` holds the stored word.
- R6: A request to the open row causes no row strobe activity. Column strobe falls in page mode are at least ceil(T_PC/Tclk) cycles apart, and the column strobes stay high at least ceil(T_CP/Tclk) cycles between them.
- R7: A request to a row other than the open one closes the row, precharges, and opens the new row with exactly one new row strobe fall.
- R8: A row stays open no longer than floor(T_RAS_MAX/Tclk) cycles. An idle open row is closed automatically before that limit, and the next access reopens it.
- R9: When `ref_req_i` is high in idle, the controller closes any open row and precharges for at least ceil(T_RP/Tclk) cycles before raising `ref_gnt_o`. While the grant is high, all strobes stay inactive and `ready_o` is low. The grant drops after `ref_req_i` falls.
- R10: `ready_o` is high only while the controller is idle and no refresh is pending. A request is taken only when `req_i` and `ready_o` are both high, and `req_i` has no effect while `ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 22 | Word address, row in upper 11 bits |
| be_i | input | 4 | Byte-lane enables for writes |
| wdata_i | input | 36 | Write data, four 9-bit lanes |
| ready_o | output | 1 | Controller can take a request this cycle |
| rvalid_o | output | 1 | Read data valid pulse |
| rdata_o | output | 36 | Read data |
| ref_req_i | input | 1 | Refresh sequencer asks for the bus |
| ref_gnt_o | output | 1 | Bus granted to the refresh sequencer |
| dram_a_o | output | 11 | Multiplexed row/column address |
| dram_ras_no | output | 2 | Row strobes, bit 0 lanes 0-1, bit 1 lanes 2-3 |
| dram_cas_no | output | 4 | Column strobes, one per lane |
| dram_we_no | output | 1 | Write enable, active low |
| dram_dq_o | output | 36 | Data driven to the memory |
| dram_dq_oe_o | output | 1 | Drive enable for `dram_dq_o` |
| dram_dq_i | input | 36 | Data returned from the memory |

## Verification
Assertions check these rules on every cycle:
- write enable is low ahead of each column strobe fall, and the data bus is never driven during a read strobe;
- no lane is strobed without its row strobe;
- each row-strobe low period reaches its minimum, and an open row never reaches the maximum row age;
- the bus stays quiet during a refresh grant;
- `rvalid_o` follows the end of a column strobe.

Only the bench scenarios can show the address mapping, that the data written comes back merged per byte enable, and the precharge and page-period spacing measured at the pins. They also show the row strobe counts that separate page hits from misses, the automatic close of an idle row, and that a request held during a refresh grant is ignored.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_CLOSE, S_PRE, S_ROW, S_RCD, S_COL, S_CAS, S_REF
  } dstate_e;

  function automatic int ns2cyc(input int ns, input int per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_phase_timer.sv
module dram_phase_timer #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/dram_ras_age.sv
module dram_ras_age #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         open_i,
  output logic [W-1:0] age_o
);
  localparam logic [W-1:0] SAT = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_o <= '0;
    else if (!open_i)      age_o <= '0;
    else if (age_o != SAT) age_o <= age_o + 1'b1;
  end
endmodule

// File: rtl/dram_lane_io.sv
module dram_lane_io #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int RAS_N  = 2,
  localparam int DW    = LANES * LANE_W,
  localparam int LPR   = LANES / RAS_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             row_open_i,
  input  logic             cas_act_i,
  input  logic             rd_i,
  input  logic [LANES-1:0] be_i,
  input  logic             capture_i,
  input  logic [DW-1:0]    dq_i,
  output logic [RAS_N-1:0] ras_n_o,
  output logic [LANES-1:0] cas_n_o,
  output logic [DW-1:0]    rdata_o
);

  for (genvar h = 0; h < RAS_N; h++) begin : g_ras
    assign ras_n_o[h] = ~row_open_i;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    // reads strobe every lane, writes only the enabled ones
    assign cas_n_o[k] = ~(cas_act_i & (rd_i | be_i[k]));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        rdata_o[k*LANE_W +: LANE_W] <= '0;
      else if (capture_i) rdata_o[k*LANE_W +: LANE_W] <= dq_i[k*LANE_W +: LANE_W];
    end

    p_cas_under_ras_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cas_n_o[k] |-> !ras_n_o[k / LPR]);
  end

endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int CLK_NS       = 10,
  parameter int ROW_W        = 11,
  parameter int LANES        = 4,
  parameter int LANE_W       = 9,
  parameter int RAS_N        = 2,
  parameter int T_RC_NS      = 110,
  parameter int T_RP_NS      = 40,
  parameter int T_RAS_NS     = 60,
  parameter int T_RAS_MAX_NS = 200000,
  parameter int T_RCD_NS     = 20,
  parameter int T_RAH_NS     = 10,
  parameter int T_CAS_NS     = 15,
  parameter int T_CAC_NS     = 15,
  parameter int T_CAH_NS     = 15,
  parameter int T_CP_NS      = 10,
  parameter int T_PC_NS      = 40,
  parameter int T_RAC_NS     = 60,
  localparam int AW          = 2 * ROW_W,
  localparam int DW          = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [LANES-1:0] be_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             ready_o,
  output logic             rvalid_o,
  output logic [DW-1:0]    rdata_o,
  input  logic             ref_req_i,
  output logic             ref_gnt_o,
  output logic [ROW_W-1:0] dram_a_o,
  output logic [RAS_N-1:0] dram_ras_no,
  output logic [LANES-1:0] dram_cas_no,
  output logic             dram_we_no,
  output logic [DW-1:0]    dram_dq_o,
  output logic             dram_dq_oe_o,
  input  logic [DW-1:0]    dram_dq_i
);

  localparam int RP_C   = ns2cyc(T_RP_NS, CLK_NS);
  localparam int RAS_C  = ns2cyc(T_RAS_NS, CLK_NS);
  localparam int RC_C   = ns2cyc(T_RC_NS, CLK_NS);
  localparam int RAH_C  = ns2cyc(T_RAH_NS, CLK_NS);
  localparam int CP_C   = ns2cyc(T_CP_NS, CLK_NS);
  localparam int PC_C   = ns2cyc(T_PC_NS, CLK_NS);
  localparam int RAC_C  = ns2cyc(T_RAC_NS, CLK_NS);
  localparam int CAS_C  = imax(imax(ns2cyc(T_CAS_NS, CLK_NS), ns2cyc(T_CAC_NS, CLK_NS)),
                               imax(ns2cyc(T_CAH_NS, CLK_NS), 1));
  // one idle cycle always separates page cycles
  localparam int COL_C  = imax(imax(CP_C, PC_C - CAS_C - 1), 1);
  localparam int RCD_C  = imax(imax(ns2cyc(T_RCD_NS, CLK_NS) - COL_C, RAH_C), 1);
  localparam int PRE_C  = imax(RP_C, RC_C - RAS_C);
  localparam int RAS_MAX_C   = T_RAS_MAX_NS / CLK_NS;
  localparam int RAS_CLOSE_C = RAS_MAX_C - (COL_C + CAS_C + 2);
  localparam int AGE_W  = $clog2(RAS_MAX_C + 1);
  localparam int TMR_MAX = imax(imax(PRE_C, RCD_C), imax(COL_C, CAS_C));
  localparam int TMR_W  = imax($clog2(TMR_MAX), 1);

  localparam logic [TMR_W-1:0] PRE_L = TMR_W'(PRE_C - 1);
  localparam logic [TMR_W-1:0] RCD_L = TMR_W'(RCD_C - 1);
  localparam logic [TMR_W-1:0] COL_L = TMR_W'(COL_C - 1);
  localparam logic [TMR_W-1:0] CAS_L = TMR_W'(CAS_C - 1);
  localparam logic [AGE_W-1:0] AGE_CLOSE_OK = AGE_W'(RAS_C - 1);
  localparam logic [AGE_W-1:0] AGE_RAS_MIN  = AGE_W'(RAS_C);
  localparam logic [AGE_W-1:0] AGE_RAC      = AGE_W'(RAC_C);
  localparam logic [AGE_W-1:0] AGE_TIMEOUT  = AGE_W'(RAS_CLOSE_C);
  localparam logic [AGE_W-1:0] AGE_LIMIT    = AGE_W'(RAS_MAX_C);

  dstate_e state_q, state_d;

  logic             row_open_q;
  logic [ROW_W-1:0] open_row_q;
  logic             pend_q;
  logic             pend_we_q;
  logic [ROW_W-1:0] pend_row_q, pend_col_q;
  logic [LANES-1:0] pend_be_q;
  logic [DW-1:0]    pend_wdata_q;
  logic             rvalid_q;

  logic             tmr_load, tmr_done;
  logic [TMR_W-1:0] tmr_val;
  logic [AGE_W-1:0] ras_age;
  logic             accept, capture, timeout, page_hit;
  logic             col_phase, wr_phase;

  dram_phase_timer #(.W(TMR_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  dram_ras_age #(.W(AGE_W)) i_age (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .open_i (row_open_q),
    .age_o  (ras_age)
  );

  assign timeout  = row_open_q && (ras_age >= AGE_TIMEOUT);
  assign page_hit = row_open_q && (addr_i[AW-1:ROW_W] == open_row_q);
  assign ready_o  = (state_q == S_IDLE) && !ref_req_i && !timeout;
  assign accept   = req_i && ready_o;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (ref_req_i)   state_d = row_open_q ? S_CLOSE : S_REF;
        else if (timeout) state_d = S_CLOSE;
        else if (req_i) begin
          if (page_hit) begin
            state_d  = S_COL;
            tmr_load = 1'b1;
            tmr_val  = COL_L;
          end else if (row_open_q) state_d = S_CLOSE;
          else                     state_d = S_ROW;
        end
      end
      S_CLOSE: if (ras_age >= AGE_CLOSE_OK) begin
        state_d  = S_PRE;
        tmr_load = 1'b1;
        tmr_val  = PRE_L;
      end
      S_PRE:   if (tmr_done) state_d = pend_q ? S_ROW : S_IDLE;
      S_ROW: begin
        state_d  = S_RCD;
        tmr_load = 1'b1;
        tmr_val  = RCD_L;
      end
      S_RCD: if (tmr_done) begin
        state_d  = S_COL;
        tmr_load = 1'b1;
        tmr_val  = COL_L;
      end
      S_COL: if (tmr_done) begin
        state_d  = S_CAS;
        tmr_load = 1'b1;
        tmr_val  = CAS_L;
      end
      // one spare cycle on the row access time keeps capture off the data edge
      S_CAS: if (tmr_done && ras_age >= AGE_RAC) begin
        state_d = S_IDLE;
        capture = !pend_we_q;
      end
      S_REF:   if (!ref_req_i) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      row_open_q <= 1'b0;
      open_row_q <= '0;
      pend_q     <= 1'b0;
      rvalid_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      rvalid_q <= capture;
      if (state_q == S_ROW) begin
        row_open_q <= 1'b1;
        open_row_q <= pend_row_q;
      end else if (state_q == S_CLOSE && state_d == S_PRE) begin
        row_open_q <= 1'b0;
      end
      if (accept)                                   pend_q <= 1'b1;
      else if (state_q == S_CAS && state_d == S_IDLE) pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_we_q    <= 1'b0;
      pend_row_q   <= '0;
      pend_col_q   <= '0;
      pend_be_q    <= '0;
      pend_wdata_q <= '0;
    end else if (accept) begin
      pend_we_q    <= we_i;
      pend_row_q   <= addr_i[AW-1:ROW_W];
      pend_col_q   <= addr_i[ROW_W-1:0];
      pend_be_q    <= be_i;
      pend_wdata_q <= wdata_i;
    end
  end

  assign col_phase    = (state_q == S_COL) || (state_q == S_CAS);
  assign wr_phase     = col_phase && pend_we_q;
  assign dram_a_o     = col_phase ? pend_col_q : pend_row_q;
  assign dram_we_no   = ~wr_phase;
  assign dram_dq_oe_o = wr_phase;
  assign dram_dq_o    = pend_wdata_q;
  assign ref_gnt_o    = (state_q == S_REF);
  assign rvalid_o     = rvalid_q;

  dram_lane_io #(
    .LANES  (LANES),
    .LANE_W (LANE_W),
    .RAS_N  (RAS_N)
  ) i_lanes (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .row_open_i (row_open_q),
    .cas_act_i  (state_q == S_CAS),
    .rd_i       (!pend_we_q),
    .be_i       (pend_be_q),
    .capture_i  (capture),
    .dq_i       (dram_dq_i),
    .ras_n_o    (dram_ras_no),
    .cas_n_o    (dram_cas_no),
    .rdata_o    (rdata_o)
  );

  // assertions
  p_early_we_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(&dram_cas_no) && $past(&dram_cas_no) && !dram_we_no)
      |-> ($past(!dram_we_no) && $past(dram_dq_oe_o)));

  p_read_no_drive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(&dram_cas_no) && dram_we_no) |-> !dram_dq_oe_o);

  p_ras_min_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dram_ras_no[0]) |-> (ras_age >= AGE_RAS_MIN));

  p_ras_max_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_open_q |-> (ras_age < AGE_LIMIT));

  p_gnt_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_gnt_o |-> ((&dram_ras_no) && (&dram_cas_no) && !ready_o));

  p_rvalid_after_cas_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> ($past(state_q == S_CAS) && (&dram_cas_no)));

  p_ready_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> ((&dram_cas_no) && dram_we_no && !ref_gnt_o));

endmodule

// File: tb/test_dram_page_ctrl.sv
`timescale 1ns/1ps
module test_dram_page_ctrl;

  localparam int TCLK      = 10;
  localparam int RP_C      = (40 + TCLK - 1) / TCLK;
  localparam int RAS_C     = (60 + TCLK - 1) / TCLK;
  localparam int RCD_C     = (20 + TCLK - 1) / TCLK;
  localparam int CP_C      = (10 + TCLK - 1) / TCLK;
  localparam int PC_C      = (40 + TCLK - 1) / TCLK;
  localparam int RAS_MAX_NS = 3000;
  localparam int RAS_MAX_C = RAS_MAX_NS / TCLK;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, ref_req_i = 1'b0;
  logic [21:0] addr_i = '0;
  logic [3:0]  be_i = '0;
  logic [35:0] wdata_i = '0;
  logic        ready_o, rvalid_o, ref_gnt_o, dram_we_no, dram_dq_oe_o;
  logic [35:0] rdata_o, dram_dq_o, dram_dq_i;
  logic [10:0] dram_a_o;
  logic [1:0]  dram_ras_no;
  logic [3:0]  dram_cas_no;

  always #(TCLK/2) clk_i = ~clk_i;

  dram_page_ctrl #(.CLK_NS(TCLK), .T_RAS_MAX_NS(RAS_MAX_NS)) i_dram_page_ctrl (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .be_i, .wdata_i,
    .ready_o, .rvalid_o, .rdata_o, .ref_req_i, .ref_gnt_o,
    .dram_a_o, .dram_ras_no, .dram_cas_no, .dram_we_no,
    .dram_dq_o, .dram_dq_oe_o, .dram_dq_i
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [10:0] m_row = '0;
  longint      ras_fall_t = 0;

  always @(negedge dram_ras_no[0]) begin
    m_row      = dram_a_o;
    ras_fall_t = longint'($time);
  end

  for (genvar k = 0; k < 4; k++) begin : g_model
    logic [8:0] cells [int];
    logic [8:0] lane_q;
    initial lane_q = '0;
    assign dram_dq_i[9*k +: 9] = lane_q;
    always @(negedge dram_cas_no[k]) begin
      int key;
      longint wt;
      key = int'({m_row, dram_a_o});
      if (!dram_we_no) cells[key] = dram_dq_o[9*k +: 9];
      else begin
        lane_q = 9'h0AA;
        wt = 15;
        if (ras_fall_t + 60 > longint'($time) + 15) wt = ras_fall_t + 60 - longint'($time);
        #(wt);
        lane_q = cells.exists(key) ? cells[key] : 9'h000;
      end
    end
  end

  // ---------------- scoreboard ----------------
  logic [35:0] gold [int];
  logic [35:0] exp_q [$];
  logic [10:0] exp_row = '0, exp_col = '0;
  logic [3:0]  exp_be = '0;
  logic        exp_we = 1'b0;
  int          ras_falls = 0, cas_falls = 0;

  task automatic do_req(input logic w, input logic [21:0] a, input logic [3:0] be, input logic [35:0] d);
    logic [35:0] cur;
    @(negedge clk_i);
    while (!ready_o) @(negedge clk_i);
    req_i = 1'b1; we_i = w; addr_i = a; be_i = be; wdata_i = d;
    exp_row = a[21:11]; exp_col = a[10:0]; exp_be = be; exp_we = w;
    cur = gold.exists(int'(a)) ? gold[int'(a)] : 36'h0;
    if (w) begin
      for (int k = 0; k < 4; k++) if (be[k]) cur[9*k +: 9] = d[9*k +: 9];
      gold[int'(a)] = cur;
    end else exp_q.push_back(cur);
    @(negedge clk_i);
    req_i = 1'b0;
    chk(!ready_o, "R10 ready low after accept", ready_o, 0);
  endtask

  // ---------------- pin monitor ----------------
  bit  prev_ras_lo = 0, prev_cas_lo = 0, prev_we_lo = 0, prev_oe = 0, seen_fall = 0;
  int  lo_len = 0, hi_len = 0, cas_hi_len = 100, cas_gap = 100;

  always @(negedge clk_i) if (rst_ni) begin
    bit ras_lo, cas_lo;
    ras_lo = !dram_ras_no[0];
    cas_lo = (dram_cas_no != 4'hF);
    chk(dram_ras_no[1] == dram_ras_no[0], "R2 row strobes together", dram_ras_no, {2{dram_ras_no[0]}});
    if (ras_lo && !prev_ras_lo) begin
      ras_falls++;
      if (seen_fall) chk(hi_len >= RP_C, "R3 precharge length", hi_len, RP_C);
      seen_fall = 1;
      chk(dram_a_o == exp_row, "R2 row address", dram_a_o, exp_row);
      lo_len  = 1;
      cas_gap = 100;
    end else if (ras_lo) lo_len++;
    if (!ras_lo && prev_ras_lo) begin
      chk(lo_len >= RAS_C, "R3 row strobe low length", lo_len, RAS_C);
      chk(lo_len <= RAS_MAX_C, "R8 row strobe max length", lo_len, RAS_MAX_C);
      hi_len = 1;
    end else if (!ras_lo) hi_len++;
    if (cas_lo && !prev_cas_lo) begin
      cas_falls++;
      chk(ras_lo && (lo_len - 1) >= RCD_C, "R3 row to column delay", lo_len - 1, RCD_C);
      chk(cas_hi_len >= CP_C, "R6 column precharge", cas_hi_len, CP_C);
      chk(cas_gap >= PC_C, "R6 page period", cas_gap, PC_C);
      chk(dram_a_o == exp_col, "R2 column address", dram_a_o, exp_col);
      if (exp_we) begin
        chk(!dram_we_no && prev_we_lo && prev_oe, "R4 early write setup", {prev_we_lo, prev_oe}, 2'b11);
        chk(dram_cas_no == ~exp_be, "R4 lane strobes", dram_cas_no, ~exp_be);
      end else begin
        chk(dram_cas_no == 4'h0 && dram_we_no && !dram_dq_oe_o, "R5 read strobes",
            {dram_cas_no, dram_we_no, dram_dq_oe_o}, 6'b000010);
      end
      cas_gap = 1;
    end else cas_gap++;
    if (cas_lo && exp_we)
      chk(!dram_we_no && dram_dq_oe_o, "R4 write held", {dram_we_no, dram_dq_oe_o}, 2'b01);
    if (cas_lo) cas_hi_len = 0; else cas_hi_len++;
    if (rvalid_o) begin
      chk(!cas_lo && prev_cas_lo, "R5 rvalid timing", {cas_lo, prev_cas_lo}, 2'b01);
      if (exp_q.size() == 0) chk(0, "R5 unexpected rvalid", 1, 0);
      else begin
        logic [35:0] e;
        e = exp_q.pop_front();
        chk(rdata_o == e, "R5 read data", rdata_o, e);
      end
    end
    prev_ras_lo = ras_lo;
    prev_cas_lo = cas_lo;
    prev_we_lo  = !dram_we_no;
    prev_oe     = dram_dq_oe_o;
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL R10 watchdog expired actual=%0d expected<=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 200) begin @(negedge clk_i); n++; end
    repeat (2) @(negedge clk_i);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int f0, c0, n;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(dram_ras_no == 2'b11 && dram_cas_no == 4'hF && dram_we_no && !dram_dq_oe_o,
        "R1 pins in reset", {dram_ras_no, dram_cas_no, dram_we_no, dram_dq_oe_o}, 8'hFE);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ready_o && !ref_gnt_o && !rvalid_o, "R1 flags after reset", {ready_o, ref_gnt_o, rvalid_o}, 3'b100);
    chk(dram_ras_no == 2'b11 && dram_cas_no == 4'hF, "R1 strobes after reset", {dram_ras_no, dram_cas_no}, 6'h3F);

    // R2 R4 R5 basic write and read
    do_req(1, {11'd5, 11'd10}, 4'hF, 36'h1_2345_6789);
    do_req(0, {11'd5, 11'd10}, 4'hF, '0);
    drain();

    // R6 page hits on the same row
    f0 = ras_falls;
    do_req(1, {11'd5, 11'd11}, 4'hF, 36'hA_BCDE_F012);
    do_req(0, {11'd5, 11'd11}, 4'hF, '0);
    do_req(0, {11'd5, 11'd10}, 4'hF, '0);
    drain();
    chk(ras_falls == f0, "R6 no row strobe on page hit", ras_falls, f0);

    // R4 partial write merges lanes 0 and 2 only
    do_req(1, {11'd5, 11'd10}, 4'b0101, 36'hF_FFFF_FFFF);
    do_req(0, {11'd5, 11'd10}, 4'hF, '0);
    do_req(1, {11'd5, 11'd11}, 4'b1000, 36'h0_0000_0000);
    do_req(0, {11'd5, 11'd11}, 4'hF, '0);
    drain();

    // R7 row miss
    f0 = ras_falls;
    do_req(1, {11'd1234 % 2048, 11'd2047}, 4'hF, 36'h5_5AA5_A55A);
    do_req(0, {11'd1234 % 2048, 11'd2047}, 4'hF, '0);
    drain();
    chk(ras_falls == f0 + 1, "R7 one new row opening", ras_falls, f0 + 1);
    f0 = ras_falls;
    do_req(0, {11'd5, 11'd10}, 4'hF, '0);
    drain();
    chk(ras_falls == f0 + 1, "R7 reopen old row", ras_falls, f0 + 1);

    // R8 idle row closes before the limit
    repeat (RAS_MAX_C + 40) @(negedge clk_i);
    chk(dram_ras_no == 2'b11, "R8 idle row closed", dram_ras_no, 2'b11);
    f0 = ras_falls;
    do_req(0, {11'd5, 11'd10}, 4'hF, '0);
    drain();
    chk(ras_falls == f0 + 1, "R8 reopen after close", ras_falls, f0 + 1);

    // R9 refresh with an open row, R10 request ignored while granted
    ref_req_i = 1'b1;
    n = 0;
    while (!ref_gnt_o && n < 100) begin
      @(negedge clk_i); n++;
      if (!ref_gnt_o) chk(!ready_o, "R9 ready low while refresh pending", ready_o, 0);
    end
    chk(ref_gnt_o, "R9 grant raised", ref_gnt_o, 1);
    chk(dram_ras_no == 2'b11 && hi_len >= RP_C, "R9 precharged before grant", hi_len, RP_C);
    c0 = cas_falls; f0 = ras_falls;
    req_i = 1'b1; we_i = 1'b1; addr_i = {11'd7, 11'd7}; be_i = 4'hF; wdata_i = 36'h0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      chk(ref_gnt_o && !ready_o && dram_ras_no == 2'b11 && dram_cas_no == 4'hF,
          "R9 bus quiet during grant", {ref_gnt_o, ready_o, dram_ras_no, dram_cas_no}, 8'hBF);
    end
    req_i = 1'b0;
    @(negedge clk_i);
    chk(cas_falls == c0 && ras_falls == f0, "R10 request ignored while not ready", cas_falls, c0);
    ref_req_i = 1'b0;
    @(negedge clk_i);
    chk(!ref_gnt_o && ready_o, "R9 grant released", {ref_gnt_o, ready_o}, 2'b01);

    // R9 refresh with no open row, then data still intact
    ref_req_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(ref_gnt_o, "R9 grant with row closed", ref_gnt_o, 1);
    ref_req_i = 1'b0;
    do_req(0, {11'd5, 11'd11}, 4'hF, '0);
    do_req(0, {11'd7, 11'd7}, 4'hF, '0);
    drain();
    chk(exp_q.size() == 0, "R5 all reads returned", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule